// File: doc/BRIEF.md
# Fractional 8x8 Multiplier With Selectable Signedness

This block multiplies two 8-bit operands and returns a 16-bit product, split into a high byte and a low byte for a fixed register pair. A mode input sets how each operand is read. Both can be unsigned. Both can be two's complement. Or the first can be two's complement while the second stays unsigned. A fractional select shifts the product left by one bit, which suits fixed-point values with the binary point after the top bit. Only two flags are produced. Carry is the top bit of the product before any shift. Zero reports whether the delivered 16-bit result is zero.

An operation begins when `start` is seen in the idle state. The operands, mode and fractional select are captured on that edge. The product is registered on the next edge, and `done` is high for the cycle that follows. The controller has three states: ST_IDLE, ST_CALC and ST_DONE. ST_IDLE moves to ST_CALC when start is seen, and otherwise stays in ST_IDLE. ST_CALC always moves to ST_DONE, and that edge loads the result. ST_DONE always returns to ST_IDLE. A start seen in ST_CALC or ST_DONE is ignored.

Top module: `frac_mul8`

## Requirements
- R1: With mode 2'b00 both operands are unsigned, and the result is opa*opb as a 16-bit value.
- R2: With mode 2'b01 both operands are two's complement, and the result is the signed product in 16-bit two's complement.
- R3: With mode 2'b10, opa is two's complement and opb is unsigned, and the result is their product in 16-bit two's complement.
- R4: Mode 2'b11 behaves exactly as mode 2'b00.
- R5: With frac=1 the result is the 16-bit product shifted left by one, dropping the top bit. Result bit 0 is then always 0.
- R6: c_flag equals bit 15 of the product before the fractional shift.
- R7: z_flag is 1 exactly when the delivered 16-bit result is zero, including after the fractional shift.
- R8: When start is seen at edge k in the idle state, done is high only in the cycle after edge k+1. The result and flags are valid in that same cycle.
- R9: A start seen while an operation is in progress (ST_CALC or ST_DONE) starts nothing and produces no extra done pulse.
- R10: Operands, mode and frac are captured on the accepting edge. Later changes on those inputs do not affect that operation's result.
- R11: After reset, result, z_flag, c_flag and done are all 0.
- R12: result, z_flag and c_flag hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| mode | input | 2 | 00 unsigned x unsigned, 01 signed x signed, 10 signed x unsigned, 11 same as 00 |
| frac | input | 1 | 1 selects the fractional (left-shifted) result |
| result | output | 16 | Product; bits 15:8 high byte, bits 7:0 low byte |
| z_flag | output | 1 | Result-is-zero flag |
| c_flag | output | 1 | Bit 15 of the unshifted product |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions assume that start, the operands, mode and frac change only away from the rising clock edge. They also assume the reset is held for at least one edge before any start. The bench drives every input at the falling edge and keeps start low throughout reset. Because of this, each accepted start shows up cleanly two edges later. The busy-start and input-change scenarios raise start or change operands only in the cycles after acceptance. This keeps the ignore and capture properties meaningful without racing the edge.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;

    typedef enum logic [1:0] {
        MM_UU  = 2'b00,
        MM_SS  = 2'b01,
        MM_SU  = 2'b10,
        MM_RSV = 2'b11
    } mul_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_CALC = 2'b01,
        ST_DONE = 2'b10
    } mul_state_t;

endpackage

// File: rtl/mul_opnd_ext.sv
module mul_opnd_ext #(
    parameter int W = 8
) (
    input  logic [W-1:0]        raw,
    input  logic                sign_en,
    output logic signed [W:0]   ext
);
    // One extra bit lets a single signed multiplier serve all modes.
    always_comb begin
        ext = $signed({sign_en & raw[W-1], raw});
    end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int W = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [1:0]       mode,
    input  logic             frac,
    output logic [2*W-1:0]   res,
    output logic             carry,
    output logic             zero
);
    import frac_mul_pkg::*;

    localparam int PW = 2 * W;
    localparam int XW = 2 * (W + 1);

    logic               sign_a, sign_b;
    logic signed [W:0]  ax, bx;
    logic signed [XW-1:0] full;
    logic [PW-1:0]      raw;

    always_comb begin
        unique case (mul_mode_t'(mode))
            MM_SS:   begin sign_a = 1'b1; sign_b = 1'b1; end
            MM_SU:   begin sign_a = 1'b1; sign_b = 1'b0; end
            MM_UU,
            MM_RSV:  begin sign_a = 1'b0; sign_b = 1'b0; end
            default: begin sign_a = 1'b0; sign_b = 1'b0; end
        endcase
    end

    mul_opnd_ext #(.W(W)) u_ext_a (.raw(a), .sign_en(sign_a), .ext(ax));
    mul_opnd_ext #(.W(W)) u_ext_b (.raw(b), .sign_en(sign_b), .ext(bx));

    always_comb begin
        full  = XW'(ax) * XW'(bx);
        raw   = full[PW-1:0];
        carry = raw[PW-1];
        res   = frac ? {raw[PW-2:0], 1'b0} : raw;
        zero  = (res == '0);
    end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic load_res,
    output logic busy,
    output logic done
);
    import frac_mul_pkg::*;

    mul_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_CALC;
            ST_CALC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        load_res = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin busy = 1'b0; accept = start; end
            ST_CALC: load_res = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/frac_mul8.sv
module frac_mul8 #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [1:0]     mode,
    input  logic           frac,
    output logic [2*W-1:0] result,
    output logic           z_flag,
    output logic           c_flag,
    output logic           done
);
    localparam int PW = 2 * W;

    logic          accept, load_res, busy;
    logic [W-1:0]  a_q, b_q;
    logic [1:0]    mode_q;
    logic          frac_q;
    logic [PW-1:0] res_c;
    logic          carry_c, zero_c;

    mul_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .load_res(load_res), .busy(busy), .done(done)
    );

    // Stage 1: capture operands on the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            mode_q <= '0;
            frac_q <= 1'b0;
        end else if (accept) begin
            a_q    <= opa;
            b_q    <= opb;
            mode_q <= mode;
            frac_q <= frac;
        end
    end

    mul_datapath #(.W(W)) u_dp (
        .a(a_q), .b(b_q), .mode(mode_q), .frac(frac_q),
        .res(res_c), .carry(carry_c), .zero(zero_c)
    );

    // Stage 2: register product and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            z_flag <= 1'b0;
            c_flag <= 1'b0;
        end else if (load_res) begin
            result <= res_c;
            z_flag <= zero_c;
            c_flag <= carry_c;
        end
    end
endmodule

// File: rtl/frac_mul8_chk.sv
module frac_mul8_chk #(
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          frac_q,
    input logic          z_flag,
    input logic [PW-1:0] result
);
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##1 done); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !busy, 2)); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R12
    AST_FRAC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (done && frac_q) |-> !result[0]); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (z_flag == (result == '0))); // R7
endmodule

bind frac_mul8 frac_mul8_chk #(.PW(2*W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .frac_q(frac_q), .z_flag(z_flag), .result(result)
);

// File: tb/tb_frac_mul8.sv
module tb_frac_mul8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opa = '0, opb = '0;
    logic [1:0]  mode = '0;
    logic        frac = 1'b0;
    logic [15:0] result;
    logic        z_flag, c_flag, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    frac_mul8 dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .mode(mode), .frac(frac), .result(result), .z_flag(z_flag),
        .c_flag(c_flag), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_prod(input logic [7:0] a, input logic [7:0] b,
                                             input logic [1:0] m);
        int av, bv, p;
        av = (m == 2'b01 || m == 2'b10) ? int'($signed(a)) : int'(a);
        bv = (m == 2'b01) ? int'($signed(b)) : int'(b);
        p  = av * bv;
        return p[15:0];
    endfunction

    task automatic check_outputs(input string req, input logic [7:0] a, input logic [7:0] b,
                                 input logic [1:0] m, input logic f);
        logic [15:0] p, r;
        p = ref_prod(a, b, m);
        r = f ? {p[14:0], 1'b0} : p;
        chk(req, int'(result), int'(r));
        chk("R6", int'(c_flag), int'(p[15]));
        chk("R7", int'(z_flag), int'(r == 16'h0));
    endtask

    // Drive at negedge; accept at edge k; result/done visible after edge k+1.
    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [1:0] m, input logic f);
        @(negedge clk);
        start = 1'b1; opa = a; opb = b; mode = m; frac = f;
        @(negedge clk);
        start = 1'b0;
        chk("R8", int'(done), 0);
        @(negedge clk);
        chk("R8", int'(done), 1);
        check_outputs(req, a, b, m, f);
        @(negedge clk);
        chk("R8", int'(done), 0);
    endtask

    task automatic t_reset;
        chk("R11", int'(result), 0);
        chk("R11", int'(z_flag), 0);
        chk("R11", int'(c_flag), 0);
        chk("R11", int'(done), 0);
    endtask

    task automatic t_unsigned;
        run_op("R1", 8'd200, 8'd250, 2'b00, 1'b0);
        run_op("R1", 8'd255, 8'd255, 2'b00, 1'b0);
        run_op("R1", 8'd0, 8'd77, 2'b00, 1'b0);
        run_op("R1", 8'd12, 8'd13, 2'b00, 1'b0);
    endtask

    task automatic t_signed;
        run_op("R2", 8'h80, 8'h80, 2'b01, 1'b0);
        run_op("R2", 8'hFF, 8'h05, 2'b01, 1'b0);
        run_op("R2", 8'h7F, 8'h81, 2'b01, 1'b0);
    endtask

    task automatic t_mixed;
        run_op("R3", 8'h80, 8'hFF, 2'b10, 1'b0);
        run_op("R3", 8'hFE, 8'h03, 2'b10, 1'b0);
        run_op("R3", 8'h7F, 8'hFF, 2'b10, 1'b0);
    endtask

    task automatic t_reserved;
        run_op("R4", 8'hF0, 8'hC0, 2'b11, 1'b0);
        run_op("R4", 8'h81, 8'h82, 2'b11, 1'b1);
    endtask

    task automatic t_fractional;
        run_op("R5", 8'h40, 8'h40, 2'b00, 1'b1);
        run_op("R5", 8'h80, 8'h80, 2'b01, 1'b1);
        run_op("R5", 8'hC0, 8'h40, 2'b01, 1'b1);
        run_op("R5", 8'h80, 8'hFF, 2'b10, 1'b1);
        run_op("R5", 8'hFF, 8'hFF, 2'b00, 1'b1);
    endtask

    task automatic t_flags;
        run_op("R7", 8'h00, 8'hFF, 2'b01, 1'b1);
        run_op("R6", 8'h90, 8'h90, 2'b00, 1'b0);
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        start = 1'b1; opa = 8'd3; opb = 8'd5; mode = 2'b00; frac = 1'b0;
        @(negedge clk);
        opa = 8'd9; opb = 8'd9;
        @(negedge clk);
        chk("R9", int'(done), 1);
        chk("R9", int'(result), 15);
        @(negedge clk);
        start = 1'b0;
        chk("R9", int'(done), 0);
        @(negedge clk);
        chk("R9", int'(done), 0);
        @(negedge clk);
        chk("R9", int'(done), 0);
        chk("R9", int'(result), 15);
    endtask

    task automatic t_capture;
        @(negedge clk);
        start = 1'b1; opa = 8'hFF; opb = 8'h02; mode = 2'b01; frac = 1'b0;
        @(negedge clk);
        start = 1'b0; opa = 8'h11; opb = 8'h22; mode = 2'b00; frac = 1'b1;
        @(negedge clk);
        chk("R10", int'(done), 1);
        chk("R10", int'(result), 16'hFFFE);
        chk("R10", int'(c_flag), 1);
        @(negedge clk);
    endtask

    task automatic t_hold;
        run_op("R12", 8'd7, 8'd6, 2'b00, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            opa = 8'(i * 37); opb = 8'(i + 90); mode = 2'(i); frac = i[0];
        end
        chk("R12", int'(result), 42);
        chk("R12", int'(z_flag), 0);
        chk("R12", int'(c_flag), 0);
        chk("R12", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unsigned();
        t_signed();
        t_mixed();
        t_reserved();
        t_fractional();
        t_flags();
        t_busy_ignore();
        t_capture();
        t_hold();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule